// File: doc/BRIEF.md
# DRAM Geometry Alias Probe

This engine sizes an attached memory without any prior knowledge of its layout. It works as a bus master on a simple read port. For each candidate address bit it checks whether the memory aliases. It fetches a window of consecutive 32-bit words at the base address and the same number of words at base plus a power-of-two offset. When every pair agrees, the address has wrapped back onto the same storage.

Three sweeps run in a fixed order. Column bits are found first. Row bits are found next, with offsets that build on the column result. A single test then decides whether the device has four or eight banks. The column figure is corrected for the data-bus width, since a 32-bit bus consumes two address bits and a 16-bit bus one. From the corrected figures the engine reports the page size in bytes, the row-bit count, the bank flag and the log2 of the total capacity. The capacity also uses the rank and channel counts supplied by the caller. A controller configuration stage downstream takes these outputs as its parameters.

Top module: `geo_probe_top`

## Requirements
- R1: One alias test reads WORDS (default 64) word pairs. For each index i it reads base+4i and then base+offset+4i. The test reports an alias only when all pairs are equal, and a mismatch never shortens the test: every run of one test makes exactly 2*WORDS transfers.
- R2: The column sweep tests offsets 2^c for c = 7 up to 19 and stops at the first alias. If no offset aliases, c is taken as 20. The shift is 2 when `bus32`=1 and 1 when `bus32`=0, and `col_bits` = c minus the shift.
- R3: `page_bytes` = 2^col_bits multiplied by twice the shift.
- R4: The row sweep tests r = 11 up to 15 with offset 2^(r+col_bits+shift) and stops at the first alias. `row_bits` is that r, or 16 when none aliases.
- R5: The bank test uses offset 2^(row_bits+col_bits+shift+2). An alias gives `bank8`=0 (four banks); no alias gives `bank8`=1 (eight banks).
- R6: `size_log2` = rank_cnt + row_bits + bank8 + col_bits + chan_cnt + shift.
- R7: Only one read is outstanding at a time. `rd_req` stays high with a stable `rd_addr` until a cycle in which `rd_vld` is high, and that cycle completes the read with `rd_data`.
- R8: `busy` is high from the cycle after an accepted start until the bank test ends. `done` then rises and stays high, with the result outputs held, until the next accepted start clears it. `done` and `busy` are never high together.
- R9: `start` is accepted only while `busy` is low. `bus32`, `rank_cnt` and `chan_cnt` are sampled at the accepted start, so a start pulse or input change during a run has no effect on its results.
- R10: After reset, `busy`, `done` and `rd_req` are low, and `rd_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (taken only when idle) |
| bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| rank_cnt | input | 2 | Rank count term of the size exponent |
| chan_cnt | input | 2 | Channel count term of the size exponent |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | AW (40) | Byte address of the read |
| rd_vld | input | 1 | Read response valid, completes the request |
| rd_data | input | 32 | Read response word |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Results valid, held until the next start |
| col_bits | output | 6 | Column address bits after bus correction |
| row_bits | output | 6 | Row address bits |
| bank8 | output | 1 | 1 = eight banks, 0 = four banks |
| page_bytes | output | 32 | Page size in bytes |
| size_log2 | output | 6 | log2 of total capacity in bytes |

## Verification
The assertions watch the read handshake on every cycle: the address holds while a request waits, and no read is requested while the engine is idle. They also check that each alias test ends only after its full count of transfers, and that `done` and `busy` exclude each other. The configuration latched at start must stay frozen for the whole run, and the found column and row figures must lie inside their sweep ranges. Whether the sweeps stop at the right bit, apply the bus correction and combine the size exponent correctly can only be shown by the bench's memory models. Each model ignores chosen address bits. One of them aliases only half of a window, which shows that a partial match is not taken as a wrap.

// File: rtl/geo_pkg.sv
package geo_pkg;
   localparam int EXP_W  = 6;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      SW_IDLE,
      SW_COL,
      SW_ROW,
      SW_BANK
   } sweep_e;
endpackage

// File: rtl/geo_alias_window.sv
module geo_alias_window
   import geo_pkg::*;
#(
   parameter int AW    = 40,
   parameter int WORDS = 64,
   parameter int BASE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [AW-1:0]     offset,
   output logic              rd_req,
   output logic [AW-1:0]     rd_addr,
   input  logic              rd_vld,
   input  logic [WORD_W-1:0] rd_data,
   output logic              fin,
   output logic              alias_hit,
   output logic              active
);
   localparam int IW = $clog2(WORDS);
   localparam int CW = $clog2(WORDS + 1);

   logic              act_q;
   logic              side_q;
   logic [IW-1:0]     idx_q;
   logic [CW-1:0]     hits_q;
   logic [WORD_W-1:0] first_q;
   logic [AW-1:0]     off_q;
   logic              fin_q;
   logic              alias_q;
   logic [CW:0]       xfer_q;
   logic              same;
   logic              last_pair;

   assign same      = (rd_data == first_q);
   assign last_pair = (idx_q == IW'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         side_q  <= 1'b0;
         idx_q   <= '0;
         hits_q  <= '0;
         first_q <= '0;
         off_q   <= '0;
         fin_q   <= 1'b0;
         alias_q <= 1'b0;
         xfer_q  <= '0;
      end else begin
         fin_q <= 1'b0;
         if (go && !act_q) begin
            act_q  <= 1'b1;
            side_q <= 1'b0;
            idx_q  <= '0;
            hits_q <= '0;
            off_q  <= offset;
            xfer_q <= '0;
         end else if (act_q && rd_vld) begin
            xfer_q <= xfer_q + 1'b1;
            if (!side_q) begin
               first_q <= rd_data;
               side_q  <= 1'b1;
            end else begin
               side_q <= 1'b0;
               hits_q <= hits_q + CW'(same);
               if (last_pair) begin
                  act_q   <= 1'b0;
                  fin_q   <= 1'b1;
                  alias_q <= ((hits_q + CW'(same)) == CW'(WORDS));
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end
   end

   assign rd_req    = act_q;
   assign rd_addr   = AW'(BASE) + (side_q ? off_q : '0) + AW'({idx_q, 2'b00});
   assign fin       = fin_q;
   assign alias_hit = alias_q;
   assign active    = act_q;

   initial begin
      assert (WORDS >= 2) else $error("WORDS must be at least 2");
   end

   // R7: a waiting request keeps its address
   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_vld) |=> (rd_req && $stable(rd_addr)));

   // R1: a test ends only after all 2*WORDS transfers
   p_full_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> (xfer_q == (CW+1)'(2 * WORDS)));
endmodule

// File: rtl/geo_sweep_fsm.sv
module geo_sweep_fsm
   import geo_pkg::*;
#(
   parameter int AW     = 40,
   parameter int COL_LO = 7,
   parameter int COL_HI = 19,
   parameter int ROW_LO = 11,
   parameter int ROW_HI = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             bus32,
   input  logic [1:0]       rank_in,
   input  logic [1:0]       chan_in,
   input  logic             test_fin,
   input  logic             test_alias,
   output logic             test_go,
   output logic [AW-1:0]    test_offset,
   output logic             busy,
   output logic             done,
   output logic [EXP_W-1:0] craw,
   output logic [EXP_W-1:0] rows,
   output logic             bank8,
   output logic [1:0]       shift,
   output logic [1:0]       rank,
   output logic [1:0]       chan
);
   sweep_e           state_q;
   logic [EXP_W-1:0] cur_q;
   logic [EXP_W-1:0] craw_q;
   logic [EXP_W-1:0] rows_q;
   logic             bank8_q;
   logic             done_q;
   logic             go_q;
   logic [AW-1:0]    off_q;
   logic [1:0]       shift_q;
   logic [1:0]       rank_q;
   logic [1:0]       chan_q;

   logic             col_last;
   logic             row_last;
   logic [EXP_W-1:0] col_pick;
   logic [EXP_W-1:0] row_pick;
   logic [EXP_W-1:0] next_exp;

   always_comb begin
      col_last = test_alias || (cur_q == EXP_W'(COL_HI));
      row_last = test_alias || (cur_q == EXP_W'(ROW_HI));
      col_pick = test_alias ? cur_q : EXP_W'(COL_HI + 1);
      row_pick = test_alias ? cur_q : EXP_W'(ROW_HI + 1);
      case (state_q)
         SW_IDLE: next_exp = EXP_W'(COL_LO);
         SW_COL:  next_exp = col_last ? EXP_W'(ROW_LO) + col_pick : cur_q + 1'b1;
         SW_ROW:  next_exp = row_last ? row_pick + craw_q + EXP_W'(2)
                                      : cur_q + 1'b1 + craw_q;
         default: next_exp = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SW_IDLE;
         cur_q   <= '0;
         craw_q  <= '0;
         rows_q  <= '0;
         bank8_q <= 1'b0;
         done_q  <= 1'b0;
         go_q    <= 1'b0;
         off_q   <= '0;
         shift_q <= 2'd0;
         rank_q  <= 2'd0;
         chan_q  <= 2'd0;
      end else begin
         go_q <= 1'b0;
         case (state_q)
            SW_IDLE: if (start) begin
               shift_q <= bus32 ? 2'd2 : 2'd1;
               rank_q  <= rank_in;
               chan_q  <= chan_in;
               done_q  <= 1'b0;
               cur_q   <= EXP_W'(COL_LO);
               go_q    <= 1'b1;
               off_q   <= AW'(1) << next_exp;
               state_q <= SW_COL;
            end
            SW_COL: if (test_fin) begin
               go_q  <= 1'b1;
               off_q <= AW'(1) << next_exp;
               if (col_last) begin
                  craw_q  <= col_pick;
                  cur_q   <= EXP_W'(ROW_LO);
                  state_q <= SW_ROW;
               end else begin
                  cur_q <= cur_q + 1'b1;
               end
            end
            SW_ROW: if (test_fin) begin
               go_q  <= 1'b1;
               off_q <= AW'(1) << next_exp;
               if (row_last) begin
                  rows_q  <= row_pick;
                  state_q <= SW_BANK;
               end else begin
                  cur_q <= cur_q + 1'b1;
               end
            end
            default: if (test_fin) begin
               bank8_q <= !test_alias;
               done_q  <= 1'b1;
               state_q <= SW_IDLE;
            end
         endcase
      end
   end

   assign test_go     = go_q;
   assign test_offset = off_q;
   assign busy        = (state_q != SW_IDLE);
   assign done        = done_q;
   assign craw        = craw_q;
   assign rows        = rows_q;
   assign bank8       = bank8_q;
   assign shift       = shift_q;
   assign rank        = rank_q;
   assign chan        = chan_q;

   initial begin
      assert (COL_LO <= COL_HI && ROW_LO <= ROW_HI)
         else $error("sweep bounds out of order");
      assert (AW > ROW_HI + COL_HI + 4)
         else $error("AW too narrow for the largest probe offset");
   end

   // R8: completion and activity never overlap
   p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && busy));

   // R9: configuration latched at start is frozen during a run
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(shift_q) && $stable(rank_q) && $stable(chan_q)));

   // R2: the found column bit lies within the sweep (or one past it)
   p_col_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (craw_q >= EXP_W'(COL_LO) && craw_q <= EXP_W'(COL_HI + 1)));

   // R4: the found row count lies within the sweep (or one past it)
   p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (rows_q >= EXP_W'(ROW_LO) && rows_q <= EXP_W'(ROW_HI + 1)));
endmodule

// File: rtl/geo_result_calc.sv
module geo_result_calc
   import geo_pkg::*;
#(
   parameter int PW = 32
) (
   input  logic [EXP_W-1:0] craw,
   input  logic [EXP_W-1:0] rows,
   input  logic             bank8,
   input  logic [1:0]       shift,
   input  logic [1:0]       rank,
   input  logic [1:0]       chan,
   output logic [EXP_W-1:0] col_bits,
   output logic [PW-1:0]    page_bytes,
   output logic [EXP_W-1:0] size_log2
);
   assign col_bits   = craw - EXP_W'(shift);
   assign page_bytes = PW'(1) << (col_bits + EXP_W'(shift));
   assign size_log2  = EXP_W'(rank) + rows + EXP_W'(bank8) + col_bits
                     + EXP_W'(chan) + EXP_W'(shift);
endmodule

// File: rtl/geo_probe_top.sv
module geo_probe_top
   import geo_pkg::*;
#(
   parameter int AW     = 40,
   parameter int WORDS  = 64,
   parameter int BASE   = 0,
   parameter int COL_LO = 7,
   parameter int COL_HI = 19,
   parameter int ROW_LO = 11,
   parameter int ROW_HI = 15,
   parameter int PW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bus32,
   input  logic [1:0]        rank_cnt,
   input  logic [1:0]        chan_cnt,
   output logic              rd_req,
   output logic [AW-1:0]     rd_addr,
   input  logic              rd_vld,
   input  logic [WORD_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic [EXP_W-1:0]  col_bits,
   output logic [EXP_W-1:0]  row_bits,
   output logic              bank8,
   output logic [PW-1:0]     page_bytes,
   output logic [EXP_W-1:0]  size_log2
);
   logic             t_go;
   logic [AW-1:0]    t_off;
   logic             t_fin;
   logic             t_alias;
   logic             t_active;
   logic [EXP_W-1:0] craw;
   logic [1:0]       shift;
   logic [1:0]       rank;
   logic [1:0]       chan;

   geo_sweep_fsm #(
      .AW(AW), .COL_LO(COL_LO), .COL_HI(COL_HI),
      .ROW_LO(ROW_LO), .ROW_HI(ROW_HI)
   ) u_sweep (
      .clk(clk), .rst_n(rst_n), .start(start), .bus32(bus32),
      .rank_in(rank_cnt), .chan_in(chan_cnt),
      .test_fin(t_fin), .test_alias(t_alias),
      .test_go(t_go), .test_offset(t_off),
      .busy(busy), .done(done), .craw(craw), .rows(row_bits),
      .bank8(bank8), .shift(shift), .rank(rank), .chan(chan)
   );

   geo_alias_window #(.AW(AW), .WORDS(WORDS), .BASE(BASE)) u_window (
      .clk(clk), .rst_n(rst_n), .go(t_go), .offset(t_off),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data),
      .fin(t_fin), .alias_hit(t_alias), .active(t_active)
   );

   geo_result_calc #(.PW(PW)) u_calc (
      .craw(craw), .rows(row_bits), .bank8(bank8), .shift(shift),
      .rank(rank), .chan(chan),
      .col_bits(col_bits), .page_bytes(page_bytes), .size_log2(size_log2)
   );

   // R10: no read traffic while the engine is idle
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req);

   // R1: a new test is launched only once the previous one has ended
   p_one_test_r1: assert property (@(posedge clk) disable iff (!rst_n)
      t_go |-> !t_active);
endmodule

// File: tb/geo_probe_top_bench.sv
module geo_probe_top_bench;
   localparam int AW = 40;

   typedef struct packed {
      logic       bus32;
      logic [1:0] rank;
      logic [1:0] chan;
      logic [5:0] m_craw;
      logic [5:0] m_rows;
      logic       m_bank8;
      logic [5:0] e_craw;
      logic [5:0] e_rows;
      logic       e_bank8;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd2, 2'd2, 6'd12, 6'd15, 1'b1, 6'd12, 6'd15, 1'b1},
      '{1'b0, 2'd1, 2'd1, 6'd11, 6'd13, 1'b0, 6'd11, 6'd13, 1'b0},
      '{1'b1, 2'd1, 2'd2, 6'd20, 6'd16, 1'b1, 6'd20, 6'd16, 1'b1},
      '{1'b0, 2'd2, 2'd1, 6'd9,  6'd11, 1'b0, 6'd9,  6'd11, 1'b0},
      '{1'b1, 2'd2, 2'd1, 6'd19, 6'd16, 1'b0, 6'd19, 6'd16, 1'b0},
      // bit 7 ignored: only half of the first window matches, no alias
      '{1'b1, 2'd1, 2'd1, 6'd7,  6'd12, 1'b0, 6'd19, 6'd16, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          bus32 = 1'b0;
   logic [1:0]    rank_cnt = 2'd0;
   logic [1:0]    chan_cnt = 2'd0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_vld = 1'b0;
   logic [31:0]   rd_data = '0;
   logic          busy, done, bank8;
   logic [5:0]    col_bits, row_bits, size_log2;
   logic [31:0]   page_bytes;

   int            n_chk = 0;
   int            n_bad = 0;
   logic [AW-1:0] z_mask = '0;
   int            xfers = 0;
   int            wcnt = 0;
   bit            hung = 1'b0;

   always #5 clk = ~clk;

   geo_probe_top u_geo_probe_top (
      .clk(clk), .rst_n(rst_n), .start(start), .bus32(bus32),
      .rank_cnt(rank_cnt), .chan_cnt(chan_cnt),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data),
      .busy(busy), .done(done), .col_bits(col_bits), .row_bits(row_bits),
      .bank8(bank8), .page_bytes(page_bytes), .size_log2(size_log2)
   );

   function automatic logic [31:0] mem_word(logic [AW-1:0] a);
      logic [AW-1:0] m;
      m = a & ~z_mask;
      return m[31:0] ^ {m[39:32], 24'h0};
   endfunction

   // memory responder: variable latency, one read at a time
   initial begin
      forever begin
         @(negedge clk);
         if (rd_vld) begin
            rd_vld = 1'b0;
            wcnt   = xfers % 3;
         end else if (rd_req) begin
            if (wcnt == 0) begin
               rd_vld  = 1'b1;
               rd_data = mem_word(rd_addr);
               xfers   = xfers + 1;
            end else begin
               wcnt = wcnt - 1;
            end
         end
      end
   end

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_model(input vec_t v);
      z_mask = '0;
      z_mask[v.m_craw] = 1'b1;
      if (v.m_rows <= 15) z_mask[v.m_rows + v.m_craw] = 1'b1;
      if (!v.m_bank8)     z_mask[v.m_rows + v.m_craw + 2] = 1'b1;
   endtask

   task automatic pulse_start(input vec_t v);
      @(negedge clk);
      bus32 = v.bus32; rank_cnt = v.rank; chan_cnt = v.chan; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n;
      n = 0;
      while (!done && n < 30000) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         hung = 1'b1;
         check("watchdog: done never rose", 0, 1);
      end
   endtask

   task automatic check_result(input vec_t v, input string tag);
      int sh, col, ncol, nrow;
      sh   = v.bus32 ? 2 : 1;
      col  = int'(v.e_craw) - sh;
      ncol = (v.e_craw <= 19) ? int'(v.e_craw) - 6 : 13;
      nrow = (v.e_rows <= 15) ? int'(v.e_rows) - 10 : 5;
      check({tag, " R2 col_bits"}, col_bits, col);
      check({tag, " R3 page_bytes"}, page_bytes, (longint'(1) << col) * (2 * sh));
      check({tag, " R4 row_bits"}, row_bits, v.e_rows);
      check({tag, " R5 bank8"}, bank8, v.e_bank8);
      check({tag, " R6 size_log2"}, size_log2,
            v.rank + v.e_rows + v.e_bank8 + col + v.chan + sh);
      check({tag, " R1 transfer count"}, xfers, 128 * (ncol + nrow + 1));
   endtask

   initial begin
      #1_900_000;
      hung = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 busy after reset", busy, 0);
      check("R10 done after reset", done, 0);
      check("R10 rd_req after reset", rd_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 rd_req idle", rd_req, 0);

      for (int i = 0; i < NV && !hung; i++) begin
         set_model(VEC[i]);
         xfers = 0;
         pulse_start(VEC[i]);
         check($sformatf("vec%0d R8 busy after start", i), busy, 1);
         check($sformatf("vec%0d R8 done cleared", i), done, 0);
         wait_done();
         @(negedge clk);
         check($sformatf("vec%0d R8 busy low at done", i), busy, 0);
         check_result(VEC[i], $sformatf("vec%0d", i));
      end

      // R8: done and results held while idle
      repeat (25) @(negedge clk);
      check("R8 done held", done, 1);
      check("R8 row_bits held", row_bits, VEC[NV-1].e_rows);

      // R9: start and input changes mid-run are ignored
      if (!hung) begin
         set_model(VEC[0]);
         xfers = 0;
         pulse_start(VEC[0]);
         repeat (60) @(negedge clk);
         bus32 = 1'b0; rank_cnt = 2'd1; chan_cnt = 2'd1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done();
         @(negedge clk);
         check_result(VEC[0], "R9 restart ignored");
         check("R9 still idle after run", busy, 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule